// File: doc/BRIEF.md
# Dual-Half Timer with Variable-Width PWM

This block is a 16-bit counting unit built from two 8-bit halves. A 2-bit mode input picks how the halves work together. They can be two separate 8-bit interval timers, an 8-bit interval timer beside an 8-bit PWM, one 16-bit interval timer, or a single PWM whose period is a power of two between 2^9 and 2^16 counts. Each half raises its own one-cycle flag, which the surrounding chip uses as an interrupt request.

The counters advance on clock-enable strobes, not on every clock. One strobe comes once per instruction cycle and a second comes at twice that rate. In the two 16-bit modes a select input picks which strobe drives the count. The match and duty values are held in shadow registers. They take effect only when the half that uses them wraps, or while the unit is stopped, so a new value never cuts a period short.

Top module: `timer_pwm_unit`

## Requirements
- R1: While rst_ni is low, both counters, all shadow registers and both flags are zero, so pwm_o is low.
- R2: While run_i is low, both counters are held at zero, no flag is raised, and the shadow registers copy lo_match_i, hi_match_i and duty_i on every clock.
- R3: In mode 0 (mode_i=0) each half counts from 0 up to its own match value and then wraps to 0. The low half uses lo_match_i and the high half uses hi_match_i, so each period is match+1 ticks. The wrap raises lo_flag_o or hi_flag_o for one clock after the wrapping edge. pwm_o stays low.
- R4: In mode 1 (mode_i=1) the low half is a timer as in R3. The high half counts freely with period 256, and pwm_o is high while the high count is below duty_i[7:0]. hi_flag_o pulses when the high count wraps from 255 to 0.
- R5: In mode 2 (mode_i=2) the halves form one counter with period {hi_match_i,lo_match_i}+1. hi_flag_o pulses at each wrap. lo_flag_o pulses each time the low byte becomes zero, which includes each wrap. pwm_o stays low.
- R6: In mode 3 (mode_i=3) the counter has period 2^N, where N = 9 + width_i (width_i from 0 to 7). pwm_o is high while the count is below duty_i. The flags behave as in R5.
- R7: In mode 3, a duty of zero keeps pwm_o low for the whole period, and a duty of 2^N or more keeps it high.
- R8: In modes 0 and 1 every count step needs cyc_en_i. In modes 2 and 3 a step needs half_en_i when half_res_i=1 and cyc_en_i when half_res_i=0; the other strobe has no effect.
- R9: Changes to the match and duty inputs while running take effect only at the next wrap of the half that uses them. In modes 2 and 3 that is the full-counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Count enable; low holds the counters at zero |
| cyc_en_i | input | 1 | Instruction-cycle step strobe |
| half_en_i | input | 1 | Half-cycle step strobe |
| mode_i | input | 2 | 0 two timers, 1 timer+PWM, 2 wide timer, 3 variable PWM |
| width_i | input | 3 | Mode 3 period exponent minus 9 |
| half_res_i | input | 1 | Modes 2/3: step on half_en_i instead of cyc_en_i |
| lo_match_i | input | 8 | Low-half (or low byte) match value |
| hi_match_i | input | 8 | High-half (or high byte) match value |
| duty_i | input | 16 | PWM duty; mode 1 uses bits 7:0 |
| pwm_o | output | 1 | PWM output |
| lo_flag_o | output | 1 | Low-half event pulse |
| hi_flag_o | output | 1 | High-half event pulse |

## Verification
The assertions assume that mode_i and width_i change only while run_i is low. If either changed while running, a counter could hold a value above its new limit. The stimulus therefore stops the unit and waits two clocks before it loads a new configuration. It changes only match and duty while running, which the shadowing is meant to absorb. The wide-mode flag check also assumes that a flag raised while running is cleared by one stopped clock before the mode changes, and the stimulus keeps to that order.

// File: rtl/tpw_pkg.sv
package tpw_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL    = 2'd0,
    MODE_TMR_PWM = 2'd1,
    MODE_WIDE    = 2'd2,
    MODE_VAR_PWM = 2'd3
  } tpw_mode_e;
endpackage

// File: rtl/tpw_half.sv
module tpw_half #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (step_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/tpw_shadow.sv
module tpw_shadow #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/timer_pwm_unit.sv
module timer_pwm_unit
  import tpw_pkg::*;
#(
  parameter  int HALF_W = 8,
  localparam int CNT_W  = 2 * HALF_W,
  localparam int SEL_W  = $clog2(HALF_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              cyc_en_i,
  input  logic              half_en_i,
  input  logic [1:0]        mode_i,
  input  logic [SEL_W-1:0]  width_i,
  input  logic              half_res_i,
  input  logic [HALF_W-1:0] lo_match_i,
  input  logic [HALF_W-1:0] hi_match_i,
  input  logic [CNT_W-1:0]  duty_i,
  output logic              pwm_o,
  output logic              lo_flag_o,
  output logic              hi_flag_o
);
  localparam logic [CNT_W-1:0] ONES = '1;

  tpw_mode_e         mode;
  logic              wide;
  logic [HALF_W-1:0] lo_cnt, hi_cnt, lo_m_sh, hi_m_sh;
  logic [CNT_W-1:0]  duty_sh, full_cnt, pwm_last;
  logic              tick_lo, tick_hi, wide_top, hi_top;
  logic              full_wrap, lo_wrap, hi_wrap, lo_roll;
  logic              lo_step, hi_step, lo_clr, hi_clr;

  assign mode     = tpw_mode_e'(mode_i);
  assign wide     = mode_i[1];
  assign full_cnt = {hi_cnt, lo_cnt};

  // last count of a 2^(HALF_W+1+width) period
  always_comb pwm_last = ONES >> (SEL_W'(HALF_W - 1) - width_i);

  always_comb begin
    tick_lo   = run_i & ((wide & half_res_i) ? half_en_i : cyc_en_i);
    tick_hi   = run_i & cyc_en_i;
    wide_top  = (mode == MODE_VAR_PWM) ? (full_cnt == pwm_last)
                                       : (full_cnt == {hi_m_sh, lo_m_sh});
    hi_top    = (mode == MODE_TMR_PWM) ? (&hi_cnt) : (hi_cnt == hi_m_sh);
    full_wrap = tick_lo & wide_top;
    if (wide) begin
      lo_step = tick_lo;
      hi_step = tick_lo & (&lo_cnt);
      lo_wrap = full_wrap;
      hi_wrap = full_wrap;
      lo_roll = tick_lo & ((&lo_cnt) | wide_top);
    end else begin
      lo_step = tick_lo;
      hi_step = tick_hi;
      lo_wrap = tick_lo & (lo_cnt == lo_m_sh);
      hi_wrap = tick_hi & hi_top;
      lo_roll = lo_wrap;
    end
    lo_clr = ~run_i | lo_wrap;
    hi_clr = ~run_i | hi_wrap;
  end

  tpw_half #(.W(HALF_W)) lo_half_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(lo_clr), .step_i(lo_step), .cnt_o(lo_cnt)
  );
  tpw_half #(.W(HALF_W)) hi_half_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(hi_clr), .step_i(hi_step), .cnt_o(hi_cnt)
  );

  tpw_shadow #(.W(HALF_W)) lo_m_sh_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(lo_clr), .d_i(lo_match_i), .q_o(lo_m_sh)
  );
  tpw_shadow #(.W(HALF_W)) hi_m_sh_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(hi_clr), .d_i(hi_match_i), .q_o(hi_m_sh)
  );
  tpw_shadow #(.W(CNT_W)) duty_sh_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(hi_clr), .d_i(duty_i), .q_o(duty_sh)
  );

  always_comb begin
    unique case (mode)
      MODE_TMR_PWM: pwm_o = hi_cnt < duty_sh[HALF_W-1:0];
      MODE_VAR_PWM: pwm_o = full_cnt < duty_sh;
      default:      pwm_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_flag_o <= 1'b0;
      hi_flag_o <= 1'b0;
    end else begin
      lo_flag_o <= lo_roll;
      hi_flag_o <= hi_wrap;
    end
  end
endmodule

// File: rtl/timer_pwm_unit_chk.sv
module timer_pwm_unit_chk #(
  parameter  int HALF_W = 8,
  localparam int CNT_W  = 2 * HALF_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              cyc_en_i,
  input logic [1:0]        mode_i,
  input logic              pwm_o,
  input logic              lo_flag_o,
  input logic              hi_flag_o,
  input logic [HALF_W-1:0] lo_cnt,
  input logic [HALF_W-1:0] hi_cnt,
  input logic [HALF_W-1:0] lo_m_sh,
  input logic [CNT_W-1:0]  duty_sh,
  input logic [CNT_W-1:0]  pwm_last
);
  a_r2_idle_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!lo_flag_o && !hi_flag_o));

  a_r2_idle_cnt_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> ({hi_cnt, lo_cnt} == '0));

  a_r3_lo_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !mode_i[1]) |-> (lo_cnt <= lo_m_sh));

  a_r6_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && mode_i == 2'd3) |-> ({hi_cnt, lo_cnt} <= pwm_last));

  a_r5_hi_flag_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1] && hi_flag_o) |-> ({hi_cnt, lo_cnt} == '0));

  a_r7_zero_duty_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_sh == '0) |-> !pwm_o);

  a_r8_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !mode_i[1] && !cyc_en_i) |=> $stable({hi_cnt, lo_cnt}));
endmodule

bind timer_pwm_unit timer_pwm_unit_chk #(.HALF_W(HALF_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .cyc_en_i(cyc_en_i),
  .mode_i(mode_i), .pwm_o(pwm_o), .lo_flag_o(lo_flag_o), .hi_flag_o(hi_flag_o),
  .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .lo_m_sh(lo_m_sh), .duty_sh(duty_sh),
  .pwm_last(pwm_last)
);

// File: tb/timer_pwm_unit_tb_top.sv
module timer_pwm_unit_tb_top;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0, cyc_en_i = 1'b0, half_en_i = 1'b0, half_res_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [2:0]  width_i = 3'd0;
  logic [7:0]  lo_match_i = 8'd0, hi_match_i = 8'd0;
  logic [15:0] duty_i = 16'd0;
  logic        pwm_o, lo_flag_o, hi_flag_o;

  timer_pwm_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .cyc_en_i(cyc_en_i),
    .half_en_i(half_en_i), .mode_i(mode_i), .width_i(width_i), .half_res_i(half_res_i),
    .lo_match_i(lo_match_i), .hi_match_i(hi_match_i), .duty_i(duty_i),
    .pwm_o(pwm_o), .lo_flag_o(lo_flag_o), .hi_flag_o(hi_flag_o)
  );

  always #(CLK_P / 2) clk_i = ~clk_i;

  typedef struct packed {
    logic [1:0]  mode;
    logic [2:0]  width;
    logic        res;
    logic [7:0]  lo_m;
    logic [7:0]  hi_m;
    logic [15:0] duty;
    logic [15:0] cycles;
    logic [15:0] e_lo;
    logic [15:0] e_hi;
    logic [15:0] e_pwm;
    logic [3:0]  req;
  } vec_t;

  // cyc_en_i strobes every other clock, half_en_i every clock
  localparam vec_t VECS [11] = '{
    '{2'd0, 3'd0, 1'b0, 8'd3, 8'd9,   16'd0,      16'd80,   16'd10, 16'd4,  16'd0,    4'd3}, // R3
    '{2'd0, 3'd0, 1'b0, 8'd0, 8'd255, 16'd0,      16'd80,   16'd40, 16'd0,  16'd0,    4'd3}, // R3
    '{2'd1, 3'd0, 1'b0, 8'd4, 8'd0,   16'd64,     16'd600,  16'd60, 16'd1,  16'd216,  4'd4}, // R4
    '{2'd1, 3'd0, 1'b0, 8'd1, 8'd0,   16'd0,      16'd20,   16'd5,  16'd0,  16'd0,    4'd4}, // R4
    '{2'd2, 3'd0, 1'b0, 8'd5, 8'd1,   16'd0,      16'd600,  16'd2,  16'd1,  16'd0,    4'd5}, // R5, R8
    '{2'd2, 3'd0, 1'b1, 8'd9, 8'd0,   16'd0,      16'd100,  16'd10, 16'd10, 16'd0,    4'd5}, // R5, R8
    '{2'd3, 3'd0, 1'b0, 8'd0, 8'd0,   16'd100,    16'd1200, 16'd2,  16'd1,  16'd376,  4'd6}, // R6
    '{2'd3, 3'd0, 1'b1, 8'd0, 8'd0,   16'd600,    16'd700,  16'd2,  16'd1,  16'd700,  4'd7}, // R7
    '{2'd3, 3'd7, 1'b1, 8'd0, 8'd0,   16'h8000,   16'd300,  16'd1,  16'd0,  16'd300,  4'd6}, // R6
    '{2'd3, 3'd0, 1'b1, 8'd0, 8'd0,   16'd0,      16'd600,  16'd2,  16'd1,  16'd0,    4'd7}, // R7
    '{2'd3, 3'd1, 1'b1, 8'd0, 8'd0,   16'd1000,   16'd1100, 16'd4,  16'd1,  16'd1076, 4'd6}  // R6
  };

  int n_chk = 0, n_bad = 0;
  int t_lo, t_hi, t_pwm, samp;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic configure(logic [1:0] m, logic [2:0] w, logic r,
                           logic [7:0] lm, logic [7:0] hm, logic [15:0] d);
    run_i = 1'b0; cyc_en_i = 1'b0; half_en_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    mode_i = m; width_i = w; half_res_i = r;
    lo_match_i = lm; hi_match_i = hm; duty_i = d;
    @(negedge clk_i); @(negedge clk_i);
    t_lo = 0; t_hi = 0; t_pwm = 0; samp = 0;
  endtask

  // cyc_mode: 0 alternate, 1 always, 2 never
  task automatic run_for(int n, int cyc_mode, logic run);
    for (int i = 0; i < n; i++) begin
      run_i     = run;
      half_en_i = 1'b1;
      cyc_en_i  = (cyc_mode == 1) || (cyc_mode == 0 && samp % 2 == 0);
      @(negedge clk_i);
      samp++;
      t_lo  += int'(lo_flag_o);
      t_hi  += int'(hi_flag_o);
      t_pwm += int'(pwm_o);
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state with a nonzero duty presented
    mode_i = 2'd3; duty_i = 16'd5;
    repeat (3) @(negedge clk_i);
    check("R1 pwm", int'(pwm_o), 0);
    check("R1 lo_flag", int'(lo_flag_o), 0);
    check("R1 hi_flag", int'(hi_flag_o), 0);
    rst_ni = 1'b1;

    foreach (VECS[k]) begin
      configure(VECS[k].mode, VECS[k].width, VECS[k].res,
                VECS[k].lo_m, VECS[k].hi_m, VECS[k].duty);
      run_for(int'(VECS[k].cycles), 0, 1'b1);
      check($sformatf("R%0d v%0d lo", VECS[k].req, k), t_lo, int'(VECS[k].e_lo));
      check($sformatf("R%0d v%0d hi", VECS[k].req, k), t_hi, int'(VECS[k].e_hi));
      check($sformatf("R%0d v%0d pwm", VECS[k].req, k), t_pwm, int'(VECS[k].e_pwm));
    end

    // R2: strobes ignored while stopped
    configure(2'd0, 3'd0, 1'b0, 8'd0, 8'd0, 16'd0);
    run_for(20, 1, 1'b0);
    check("R2 stopped lo", t_lo, 0);
    check("R2 stopped hi", t_hi, 0);
    // R2: count held at zero while stopped, seen through pwm
    configure(2'd3, 3'd0, 1'b1, 8'd0, 8'd0, 16'd1);
    run_for(5, 1, 1'b0);
    check("R2 held zero pwm", int'(pwm_o), 1);
    run_for(1, 1, 1'b1);
    check("R2 first step pwm", int'(pwm_o), 0);

    // R8: wide timer on cycle strobe ignores half strobe
    configure(2'd2, 3'd0, 1'b0, 8'd0, 8'd0, 16'd0);
    run_for(20, 2, 1'b1);
    check("R8 no cyc strobe hi", t_hi, 0);
    run_for(6, 1, 1'b1);
    check("R8 cyc strobe hi", t_hi, 6);

    // R9: duty change mid-period waits for the wrap
    configure(2'd3, 3'd0, 1'b1, 8'd0, 8'd0, 16'd100);
    run_for(50, 1, 1'b1);
    duty_i = 16'd400;
    run_for(150, 1, 1'b1);
    check("R9 old duty count 200", int'(pwm_o), 0);
    run_for(512, 1, 1'b1);
    check("R9 new duty count 200", int'(pwm_o), 1);
    run_for(250, 1, 1'b1);
    check("R9 new duty count 450", int'(pwm_o), 0);

    // R9: match change mid-period in mode 0
    configure(2'd0, 3'd0, 1'b0, 8'd3, 8'd255, 16'd0);
    run_for(2, 1, 1'b1);
    lo_match_i = 8'd9;
    run_for(2, 1, 1'b1);
    check("R9 old match wrap", int'(lo_flag_o), 1);
    run_for(9, 1, 1'b1);
    check("R9 new match no wrap", int'(lo_flag_o), 0);
    run_for(1, 1, 1'b1);
    check("R9 new match wrap", int'(lo_flag_o), 1);

    run_i = 1'b0;
    @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule